// File: doc/BRIEF.md
# Lamp Fault Monitor with Debounce

This block supervises three low-side LED channels: turn, stop and tail. Each channel delivers three digital inputs: an enable, a flag from an under-current comparator that shows a broken LED string, and a flag from an over-current comparator. The block filters these flags against switching noise. It drives one active-low fault indication, which an external weak pull-up stage turns into an open-drain line. It also drives one gate request per channel that chops the low-side driver while that channel is in over-current.

The two filter delays are different. A channel's fault becomes qualified only after its raw condition has held for `ASSERT_DLY` clock cycles. A qualified fault clears only after the condition has been absent for `RELEASE_DLY` cycles. Either count restarts whenever the raw condition returns to the qualified level. A disabled channel cannot report a fault, and disabling a channel drops its state at the next clock edge. Over-current chopping does not wait for qualification. It starts at the first edge that sees the flag, with a fixed off/on pattern set by `CHOP_OFF` and `CHOP_ON`.

Top module: `lamp_fault_mon`

## Requirements
- R1: After reset, `faultOut_n` is 1 and every bit of `chopGate` is 1.
- R2: A channel's raw fault condition is its enable AND (its under-current flag OR its over-current flag). Bit 0 is turn, bit 1 is stop and bit 2 is tail.
- R3: A channel's fault becomes qualified at the clock edge on which its raw condition has been 1 for `ASSERT_DLY` consecutive edges.
- R4: A qualified fault clears at the edge on which the channel has been enabled with its raw condition at 0 for `RELEASE_DLY` consecutive edges.
- R5: If the raw condition returns to the qualified level before a delay has completed, the pending count restarts from zero. A pulse shorter than the delay has no effect on `faultOut_n`.
- R6: At any edge where a channel's enable is 0, that channel's qualified fault and pending count are cleared, and its flags are ignored.
- R7: `faultOut_n` is 0 exactly while at least one channel holds a qualified fault.
- R8: While a channel is enabled and its over-current flag is 1, its `chopGate` bit is 0 for `CHOP_OFF` cycles and then 1 for `CHOP_ON` cycles, repeating. The pattern starts with the first edge that samples the flag.
- R9: After any edge where a channel is disabled or its over-current flag is 0, that channel's `chopGate` bit is 1.
- R10: The channels are independent. Activity on one channel changes neither the counts nor the chop phase of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chEnable | input | 3 | Per-channel enable (bit 0 turn, 1 stop, 2 tail) |
| underFlag | input | 3 | Per-channel under-current comparator output |
| overFlag | input | 3 | Per-channel over-current comparator output |
| faultOut_n | output | 1 | Active-low qualified fault indication |
| chopGate | output | 3 | Per-channel driver permit, 0 during the chop-off phase |

## Verification
On every cycle, the assertions check four properties:
- a disabled channel never keeps a qualified fault;
- a qualified fault only appears after an enabled channel had a flag set;
- the chop gate stays high unless the previous edge saw an over-current on an enabled channel, and it never stays low longer than `CHOP_OFF` cycles;
- a low fault output always follows an edge where some channel was enabled.

The exact assert and release edges, the restart of a pending count after a glitch, the chop phase sequence and the independence of the channels are shown only by the bench. It compares both outputs on every clock against a behavioural model.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic cntClr;   // restart the qualification count
    logic cntInc;   // advance the qualification count
    logic qLoad;    // update the qualified fault state
    logic qVal;     // value loaded into the qualified state
    logic actNext;  // chopping active in the next cycle
    logic phClr;    // restart the chop phase
    logic phInc;    // advance the chop phase
  } chStrobe_t;

endpackage

// File: rtl/lfm_ctrl.sv
module lfm_ctrl
  import lfm_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] underFlag,
  input  logic [NUM_CH-1:0] overFlag,
  input  logic [NUM_CH-1:0] qState,
  input  logic [NUM_CH-1:0] cntDone,
  input  logic [NUM_CH-1:0] actState,
  input  logic [NUM_CH-1:0] phWrap,
  output chStrobe_t [NUM_CH-1:0] strb
);

  logic [NUM_CH-1:0] rawFault;
  logic [NUM_CH-1:0] overLive;

  assign rawFault = chEnable & (underFlag | overFlag);
  assign overLive = chEnable & overFlag;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      strb[i] = '0;
      // qualification decision
      if (!chEnable[i]) begin
        strb[i].cntClr = 1'b1;
        strb[i].qLoad  = 1'b1;
        strb[i].qVal   = 1'b0;
      end else if (rawFault[i] == qState[i]) begin
        strb[i].cntClr = 1'b1;
      end else if (cntDone[i]) begin
        strb[i].cntClr = 1'b1;
        strb[i].qLoad  = 1'b1;
        strb[i].qVal   = rawFault[i];
      end else begin
        strb[i].cntInc = 1'b1;
      end
      // chop decision
      strb[i].actNext = overLive[i];
      if (!overLive[i] || !actState[i] || phWrap[i]) begin
        strb[i].phClr = 1'b1;
      end else begin
        strb[i].phInc = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lfm_datapath.sv
module lfm_datapath
  import lfm_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int ASSERT_DLY  = 16,
  parameter int RELEASE_DLY = 24,
  parameter int CHOP_ON     = 3,
  parameter int CHOP_OFF    = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  chStrobe_t [NUM_CH-1:0] strb,
  output logic [NUM_CH-1:0]      qState,
  output logic [NUM_CH-1:0]      cntDone,
  output logic [NUM_CH-1:0]      actState,
  output logic [NUM_CH-1:0]      phWrap,
  output logic [NUM_CH-1:0]      chopGate,
  output logic                   faultOut_n
);

  localparam int CNT_MAX = (ASSERT_DLY > RELEASE_DLY) ? ASSERT_DLY : RELEASE_DLY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PERIOD  = CHOP_ON + CHOP_OFF;
  localparam int PH_W    = $clog2(PERIOD + 1);
  localparam logic [CNT_W-1:0] ASR_LAST = CNT_W'(ASSERT_DLY - 1);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(RELEASE_DLY - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0]  OFF_END  = PH_W'(CHOP_OFF);

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [CNT_W-1:0] cnt;
    logic [PH_W-1:0]  ph;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt         <= '0;
        qState[g]   <= 1'b0;
        actState[g] <= 1'b0;
        ph          <= '0;
      end else begin
        if (strb[g].cntClr)      cnt <= '0;
        else if (strb[g].cntInc) cnt <= cnt + 1'b1;
        if (strb[g].qLoad)       qState[g] <= strb[g].qVal;
        actState[g] <= strb[g].actNext;
        if (strb[g].phClr)       ph <= '0;
        else if (strb[g].phInc)  ph <= ph + 1'b1;
      end
    end

    assign cntDone[g]  = (cnt == (qState[g] ? REL_LAST : ASR_LAST));
    assign phWrap[g]   = (ph == PH_LAST);
    assign chopGate[g] = ~actState[g] | (ph >= OFF_END);
  end

  assign faultOut_n = ~(|qState);

endmodule

// File: rtl/lamp_fault_mon.sv
module lamp_fault_mon
  import lfm_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int ASSERT_DLY  = 16,
  parameter int RELEASE_DLY = 24,
  parameter int CHOP_ON     = 3,
  parameter int CHOP_OFF    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] underFlag,
  input  logic [NUM_CH-1:0] overFlag,
  output logic              faultOut_n,
  output logic [NUM_CH-1:0] chopGate
);

  chStrobe_t [NUM_CH-1:0] strb;
  logic [NUM_CH-1:0] qState;
  logic [NUM_CH-1:0] cntDone;
  logic [NUM_CH-1:0] actState;
  logic [NUM_CH-1:0] phWrap;

  lfm_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .chEnable (chEnable),
    .underFlag(underFlag),
    .overFlag (overFlag),
    .qState   (qState),
    .cntDone  (cntDone),
    .actState (actState),
    .phWrap   (phWrap),
    .strb     (strb)
  );

  lfm_datapath #(
    .NUM_CH     (NUM_CH),
    .ASSERT_DLY (ASSERT_DLY),
    .RELEASE_DLY(RELEASE_DLY),
    .CHOP_ON    (CHOP_ON),
    .CHOP_OFF   (CHOP_OFF)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .qState    (qState),
    .cntDone   (cntDone),
    .actState  (actState),
    .phWrap    (phWrap),
    .chopGate  (chopGate),
    .faultOut_n(faultOut_n)
  );

endmodule

// File: rtl/lfm_checker.sv
module lfm_checker #(
  parameter int NUM_CH   = 3,
  parameter int CHOP_OFF = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chEnable,
  input logic [NUM_CH-1:0] underFlag,
  input logic [NUM_CH-1:0] overFlag,
  input logic              faultOut_n,
  input logic [NUM_CH-1:0] chopGate,
  input logic [NUM_CH-1:0] qState
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7: a low fault output needs an enabled channel at the previous edge
  assert_out_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !faultOut_n) |-> $past(|chEnable));

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    int lowRun;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           lowRun <= 0;
      else if (!chopGate[g]) lowRun <= lowRun + 1;
      else                  lowRun <= 0;
    end

    // R6: disabling drops the qualified fault at the next edge
    assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !chEnable[g] |=> !qState[g]);

    // R2: a fault only qualifies after an enabled channel had a flag set
    assert_qualify_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $rose(qState[g])) |-> $past(chEnable[g] && (underFlag[g] || overFlag[g])));

    // R9: no chopping without over-current on an enabled channel
    assert_gate_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(chEnable[g] && overFlag[g])) |-> chopGate[g]);

    // R8: the off phase never exceeds its length
    assert_chop_off_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lowRun <= CHOP_OFF);
  end

endmodule

bind lamp_fault_mon lfm_checker #(.NUM_CH(NUM_CH), .CHOP_OFF(CHOP_OFF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chEnable  (chEnable),
  .underFlag (underFlag),
  .overFlag  (overFlag),
  .faultOut_n(faultOut_n),
  .chopGate  (chopGate),
  .qState    (qState)
);

// File: tb/lamp_fault_mon_tb.sv
module lamp_fault_mon_tb;

  localparam int ASR = 16;
  localparam int REL = 24;
  localparam int CON = 3;
  localparam int COFF = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] chEnable = '0;
  logic [2:0] underFlag = '0;
  logic [2:0] overFlag = '0;
  logic       faultOut_n;
  logic [2:0] chopGate;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mq[3];
  int mrun[3];
  int mact[3];
  int mph[3];

  always #5 clk = ~clk;

  lamp_fault_mon #(
    .NUM_CH(3), .ASSERT_DLY(ASR), .RELEASE_DLY(REL), .CHOP_ON(CON), .CHOP_OFF(COFF)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .chEnable(chEnable), .underFlag(underFlag),
    .overFlag(overFlag), .faultOut_n(faultOut_n), .chopGate(chopGate)
  );

  task automatic modelUpdate();
    for (int i = 0; i < 3; i++) begin
      int raw;
      raw = (chEnable[i] && (underFlag[i] || overFlag[i])) ? 1 : 0;
      if (!chEnable[i]) begin
        mq[i] = 0; mrun[i] = 0;
      end else if (raw == mq[i]) begin
        mrun[i] = 0;
      end else begin
        mrun[i]++;
        if (mrun[i] == (mq[i] ? REL : ASR)) begin
          mq[i] = raw; mrun[i] = 0;
        end
      end
      if (chEnable[i] && overFlag[i]) begin
        mph[i] = mact[i] ? (mph[i] + 1) % (CON + COFF) : 0;
        mact[i] = 1;
      end else begin
        mact[i] = 0; mph[i] = 0;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic expF;
    logic [2:0] expG;
    expF = !(mq[0] != 0 || mq[1] != 0 || mq[2] != 0);
    for (int i = 0; i < 3; i++) expG[i] = (mact[i] == 0) || (mph[i] >= COFF);
    checks++;
    if (faultOut_n !== expF) begin
      errors++;
      $display("FAIL %s faultOut_n actual %b expected %b at %0t", tag, faultOut_n, expF, $time);
    end
    checks++;
    if (chopGate !== expG) begin
      errors++;
      $display("FAIL %s chopGate actual %b expected %b at %0t", tag, chopGate, expG, $time);
    end
  endtask

  // Inputs are applied at a falling edge; the check follows at the next falling edge
  task automatic hold(input int n, input logic [2:0] en, input logic [2:0] un,
                      input logic [2:0] ov, input string tag);
    for (int k = 0; k < n; k++) begin
      chEnable = en; underFlag = un; overFlag = ov;
      @(posedge clk);
      modelUpdate();
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin mq[i] = 0; mrun[i] = 0; mact[i] = 0; mph[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset state");
    hold(5, 3'b111, 3'b000, 3'b000, "R1 idle");
    // R5: pulse one cycle short of the assert delay
    hold(ASR - 1, 3'b001, 3'b001, 3'b000, "R5 short pulse");
    hold(3, 3'b001, 3'b000, 3'b000, "R5 short pulse gone");
    // R3: full qualification
    hold(ASR + 4, 3'b001, 3'b001, 3'b000, "R3 assert turn");
    // R5: release interrupted by a glitch, then R4 full release
    hold(10, 3'b001, 3'b000, 3'b000, "R5 release partial");
    hold(2, 3'b001, 3'b001, 3'b000, "R5 release glitch");
    hold(REL + 6, 3'b001, 3'b000, 3'b000, "R4 release turn");
    // R6: flags on a disabled channel are ignored
    hold(ASR + 4, 3'b000, 3'b010, 3'b000, "R6 disabled ignored");
    hold(10, 3'b010, 3'b010, 3'b000, "R6 pending count");
    hold(1, 3'b000, 3'b010, 3'b000, "R6 disable drops count");
    hold(10, 3'b010, 3'b010, 3'b000, "R6 count restarts");
    hold(10, 3'b010, 3'b010, 3'b000, "R3 assert stop");
    // R10, R7: two channels faulted, one released
    hold(ASR + 4, 3'b110, 3'b110, 3'b000, "R10 second channel");
    hold(REL + 6, 3'b110, 3'b100, 3'b000, "R7 one channel left");
    hold(3, 3'b010, 3'b100, 3'b000, "R6 disable clears qualified");
    // R2, R8: over-current qualifies a fault and chops the driver
    hold(ASR + 10, 3'b010, 3'b000, 3'b010, "R2 R8 over-current stop");
    hold(5, 3'b010, 3'b000, 3'b000, "R9 over removed");
    hold(5, 3'b000, 3'b000, 3'b010, "R9 over on disabled");
    hold(4, 3'b001, 3'b000, 3'b001, "R8 chop turn");
    hold(3, 3'b000, 3'b000, 3'b001, "R9 chop cut by disable");
    hold(12, 3'b101, 3'b000, 3'b101, "R10 R8 two chop channels");
    hold(REL + 6, 3'b111, 3'b000, 3'b000, "R4 final release");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

endmodule